// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt lines. It gates each line with an enable bit, and software can also raise any line through a force bit. Each line is then steered to one of two request outputs: a normal request or a fast request. Pending normal lines are ranked by a programmable 4-bit priority. A 5-bit threshold blocks every normal line whose priority does not exceed it. The number of the winning line is presented in a vector register, so the handler can read which source to serve without scanning.

Software reaches the block through a simple 32-bit register bus made of an address, a write strobe, write data and registered read data. Sources 0..31 sit in the "low" word of each per-source register pair, and sources 32..63 sit in the "high" word. A handler acknowledges a level source by clearing its enable bit, either with a whole-word write or through the set-by-number and clear-by-number registers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads zero except the normal threshold (offset 0x04), which reads 0x1F. Both request outputs are low, and both vector registers read 0xFFFF0000.
- R2: In every low/high register pair, bit k of the low word is source k and bit k of the high word is source 32+k. The pairs are: enable high 0x10 / low 0x14, type 0x18/0x1C, raw source 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64.
- R3: A type bit of 1 sends its source only to the fast pending word and the fast output. A type bit of 0 sends it only to the normal pending word and the normal vector.
- R4: The normal vector (0x40) returns, in bits 31:16, the number of the pending normal source with the largest priority. A tie goes to the higher source number. The field is 0xFFFF when nothing is pending, and bits 15:0 read zero.
- R5: There are eight priority words. Word x sits at offset 0x20 + 4*(7-x) and holds sources 8x..8x+7, with source 8x+k in bits 4k+3:4k. Each word reads back what was written.
- R6: irq_normal is high only when some pending normal source has a priority strictly greater than the 5-bit threshold. A threshold of 15 or more blocks everything. irq_fast does not depend on the threshold.
- R7: Writing n to offset 0x08 sets the enable bit of source n (bits 5:0), and writing n to 0x0C clears it. Both offsets read as zero.
- R8: The raw source word equals the input lines ORed with the force bits, so a force bit alone makes a source pending.
- R9: The fast vector (0x44) returns, in bits 31:16, the lowest-numbered pending fast source, or 0xFFFF when none is pending.
- R10: A source stays pending while its line is high and its enable bit is set. Dropping the line, or clearing the enable bit, removes it from the pending words, the vectors and the outputs.
- R11: Both request outputs are registered and change one clock after the input or register change that causes them. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| src_in | input | 64 | Level interrupt lines |
| irq_normal | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 sources, 4-bit priorities, a 32-bit bus and a 5-bit threshold. With these values both halves of every paired register are reachable. So are the top priority field of the last source (63 at level 15) and the threshold values on either side of the strict comparison (2 versus 3 at level 3, and 14 versus 15 at level 15). Priority ties between sources in different halves, forced-only fast sources and acknowledgement by clearing the enable bit are all driven through the bus, and the results are compared against the register words the requirements predict.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [7:0] A_CTRL      = 8'h00;
  localparam logic [7:0] A_NMASK     = 8'h04;
  localparam logic [7:0] A_ENSET     = 8'h08;
  localparam logic [7:0] A_ENCLR     = 8'h0C;
  localparam logic [7:0] A_ENH       = 8'h10;
  localparam logic [7:0] A_ENL       = 8'h14;
  localparam logic [7:0] A_TYH       = 8'h18;
  localparam logic [7:0] A_TYL       = 8'h1C;
  localparam logic [7:0] A_PRIO_BASE = 8'h20;
  localparam logic [7:0] A_NVEC      = 8'h40;
  localparam logic [7:0] A_FVEC      = 8'h44;
  localparam logic [7:0] A_RAWH      = 8'h48;
  localparam logic [7:0] A_RAWL      = 8'h4C;
  localparam logic [7:0] A_FRCH      = 8'h50;
  localparam logic [7:0] A_FRCL      = 8'h54;
  localparam logic [7:0] A_NPH       = 8'h58;
  localparam logic [7:0] A_NPL       = 8'h5C;
  localparam logic [7:0] A_FPH       = 8'h60;
  localparam logic [7:0] A_FPL       = 8'h64;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 4,
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int MW   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NSRC-1:0]    en,
  output logic [NSRC-1:0]    typ,
  output logic [NSRC-1:0]    frc,
  output logic [NSRC*PW-1:0] prio,
  output logic [MW-1:0]      nmask,
  output logic [DW-1:0]      ctrl
);
  localparam int HALF = NSRC / 2;
  localparam int IW   = $clog2(NSRC);
  localparam int FPR  = DW / PW;
  localparam int NPR  = NSRC / FPR;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      typ   <= '0;
      frc   <= '0;
      prio  <= '0;
      ctrl  <= '0;
      nmask <= '1;
    end else if (wr_en) begin
      if (addr == AW'(A_CTRL))  ctrl  <= wdata;
      if (addr == AW'(A_NMASK)) nmask <= wdata[MW-1:0];
      if (addr == AW'(A_ENSET)) en[wdata[IW-1:0]] <= 1'b1;
      if (addr == AW'(A_ENCLR)) en[wdata[IW-1:0]] <= 1'b0;
      if (addr == AW'(A_ENH))   en[NSRC-1:HALF]   <= wdata[HALF-1:0];
      if (addr == AW'(A_ENL))   en[HALF-1:0]      <= wdata[HALF-1:0];
      if (addr == AW'(A_TYH))   typ[NSRC-1:HALF]  <= wdata[HALF-1:0];
      if (addr == AW'(A_TYL))   typ[HALF-1:0]     <= wdata[HALF-1:0];
      if (addr == AW'(A_FRCH))  frc[NSRC-1:HALF]  <= wdata[HALF-1:0];
      if (addr == AW'(A_FRCL))  frc[HALF-1:0]     <= wdata[HALF-1:0];
      for (int r = 0; r < NPR; r++) begin
        if (addr == AW'(A_PRIO_BASE + 4 * (NPR - 1 - r)))
          prio[r*DW +: DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int NSRC = 64,
  parameter int PW   = 4,
  parameter int IW   = 6
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio,
  output logic               found,
  output logic [IW-1:0]      idx
);
  logic [PW-1:0] best;

  // Ascending scan with >= lets the higher number win a tie.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!found || prio[i*PW +: PW] >= best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irqc_low_pick.sv
module irqc_low_pick #(
  parameter int NSRC = 64,
  parameter int IW   = 6
) (
  input  logic [NSRC-1:0] pend,
  output logic            found,
  output logic [IW-1:0]   idx
);
  // Descending scan: the last hit is the lowest set bit.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 4,
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int MW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_normal,
  output logic            irq_fast
);
  localparam int HALF = NSRC / 2;
  localparam int IW   = $clog2(NSRC);
  localparam int VW   = DW / 2;
  localparam int NPR  = NSRC * PW / DW;
  localparam int PMAX = (1 << PW) - 1;

  logic [NSRC-1:0]    en, typ, frc, raw, npend, fpend;
  logic [NSRC*PW-1:0] prio;
  logic [MW-1:0]      nmask;
  logic [DW-1:0]      ctrl, nvec_w, fvec_w, rd_next;
  logic               nfound, ffound, nreq;
  logic [IW-1:0]      nidx, fidx;

  irqc_regs #(.NSRC(NSRC), .PW(PW), .DW(DW), .AW(AW), .MW(MW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en(en), .typ(typ), .frc(frc), .prio(prio), .nmask(nmask), .ctrl(ctrl)
  );

  assign raw   = src_in | frc;
  assign npend = raw & en & ~typ;
  assign fpend = raw & en & typ;

  irqc_prio_pick #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_npick (
    .pend(npend), .prio(prio), .found(nfound), .idx(nidx)
  );

  irqc_low_pick #(.NSRC(NSRC), .IW(IW)) u_fpick (
    .pend(fpend), .found(ffound), .idx(fidx)
  );

  always_comb begin
    nreq = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (npend[i] && (MW'(prio[i*PW +: PW]) > nmask)) nreq = 1'b1;
  end

  assign nvec_w = {(nfound ? VW'(nidx) : {VW{1'b1}}), {VW{1'b0}}};
  assign fvec_w = {(ffound ? VW'(fidx) : {VW{1'b1}}), {VW{1'b0}}};

  always_comb begin
    rd_next = '0;
    case (addr)
      AW'(A_CTRL):  rd_next = ctrl;
      AW'(A_NMASK): rd_next = DW'(nmask);
      AW'(A_ENH):   rd_next = en[NSRC-1:HALF];
      AW'(A_ENL):   rd_next = en[HALF-1:0];
      AW'(A_TYH):   rd_next = typ[NSRC-1:HALF];
      AW'(A_TYL):   rd_next = typ[HALF-1:0];
      AW'(A_NVEC):  rd_next = nvec_w;
      AW'(A_FVEC):  rd_next = fvec_w;
      AW'(A_RAWH):  rd_next = raw[NSRC-1:HALF];
      AW'(A_RAWL):  rd_next = raw[HALF-1:0];
      AW'(A_FRCH):  rd_next = frc[NSRC-1:HALF];
      AW'(A_FRCL):  rd_next = frc[HALF-1:0];
      AW'(A_NPH):   rd_next = npend[NSRC-1:HALF];
      AW'(A_NPL):   rd_next = npend[HALF-1:0];
      AW'(A_FPH):   rd_next = fpend[NSRC-1:HALF];
      AW'(A_FPL):   rd_next = fpend[HALF-1:0];
      default: begin
        for (int r = 0; r < NPR; r++)
          if (addr == AW'(A_PRIO_BASE + 4 * (NPR - 1 - r)))
            rd_next = prio[r*DW +: DW];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      irq_normal <= 1'b0;
      irq_fast   <= 1'b0;
    end else begin
      rdata      <= rd_next;
      irq_normal <= nreq;
      irq_fast   <= |fpend;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nmask == '1 && !irq_normal && !irq_fast)); // R1

  AST_NVEC_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    nfound |-> (npend[nidx] && !typ[nidx])); // R4

  AST_FVEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
    ffound |-> (fpend[fidx] && ((fpend & ((NSRC'(1) << fidx) - NSRC'(1))) == '0))); // R9

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (nmask >= MW'(PMAX)) |=> !irq_normal); // R6

  AST_NUM_REGS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == AW'(A_ENSET) || $past(addr) == AW'(A_ENCLR)) |-> rdata == '0); // R7
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [63:0] src_in;
  logic        irq_normal, irq_fast;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] d;
    bit          ci;
    bit          en;
    bit          ef;
    string       req;
    int          at;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .irq_normal(irq_normal), .irq_fast(irq_fast)
  );

  // Monitor: compare every item whose read has been registered.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at < cyc) begin
      item_t it;
      it = sb.pop_front();
      tests++;
      if (rdata !== it.d) begin
        fails++;
        $display("FAIL %s: addr %h rdata %h expected %h", it.req, it.a, rdata, it.d);
      end
      if (it.ci) begin
        tests++;
        if (irq_normal !== it.en || irq_fast !== it.ef) begin
          fails++;
          $display("FAIL %s: irq n/f %b%b expected %b%b", it.req,
                   irq_normal, irq_fast, it.en, it.ef);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    sb.push_back('{a, d, 1'b0, 1'b0, 1'b0, req, cyc});
  endtask

  task automatic rdi(input logic [7:0] a, input logic [31:0] d,
                     input bit n, input bit f, input string req);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    sb.push_back('{a, d, 1'b1, n, f, req, cyc});
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src_in[i] = v;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rdi(8'h04, 32'h0000001F, 0, 0, "R1");
    rd (8'h40, 32'hFFFF0000, "R1");
    rd (8'h44, 32'hFFFF0000, "R9");
    rd (8'h14, 32'h0, "R1");
    rd (8'h00, 32'h0, "R1");

    // R7 set-by-number, R2 halves
    wr(8'h08, 32'd5);
    wr(8'h08, 32'd40);
    rd(8'h14, 32'h00000020, "R7");
    rd(8'h10, 32'h00000100, "R2");
    rd(8'h08, 32'h0, "R7");

    // R6 reset threshold blocks; R4 vector with default priorities
    set_src(5, 1'b1);
    rdi(8'h5C, 32'h00000020, 0, 0, "R6");
    rd (8'h40, 32'h00050000, "R4");

    wr(8'h04, 32'h0);
    rdi(8'h04, 32'h0, 0, 0, "R6");           // prio 0 not > 0
    wr(8'h3C, 32'h00300000);                 // source 5 prio 3
    rdi(8'h3C, 32'h00300000, 1, 0, "R5");
    wr(8'h04, 32'd3);
    rdi(8'h04, 32'd3, 0, 0, "R6");           // strict comparison
    wr(8'h04, 32'd2);
    rdi(8'h40, 32'h00050000, 1, 0, "R6");

    // R4 tie across halves goes to higher number
    set_src(40, 1'b1);
    wr(8'h28, 32'h3);                        // source 40 prio 3
    rd(8'h40, 32'h00280000, "R4");
    rd(8'h58, 32'h00000100, "R2");
    wr(8'h3C, 32'h00900000);                 // source 5 prio 9
    rd(8'h40, 32'h00050000, "R4");

    // R3 routing to fast
    wr(8'h1C, 32'h20);
    rdi(8'h64, 32'h00000020, 1, 1, "R3");
    rd (8'h5C, 32'h0, "R3");
    rd (8'h44, 32'h00050000, "R9");
    rd (8'h40, 32'h00280000, "R3");

    // R6 fast ignores threshold
    wr(8'h04, 32'h1F);
    rdi(8'h44, 32'h00050000, 0, 1, "R6");

    // R8 force alone, R9 lowest fast wins
    wr(8'h54, 32'h8);
    wr(8'h08, 32'd3);
    wr(8'h1C, 32'h28);
    rd(8'h4C, 32'h00000028, "R8");
    rd(8'h44, 32'h00030000, "R9");
    rd(8'h60, 32'h0, "R2");

    // R10 acknowledge by clearing enable
    wr(8'h0C, 32'd3);
    rd (8'h44, 32'h00050000, "R10");
    wr(8'h0C, 32'd5);
    rdi(8'h44, 32'hFFFF0000, 0, 0, "R10");
    rd (8'h14, 32'h0, "R7");

    // R10 level drop
    set_src(40, 1'b0);
    rd(8'h58, 32'h0, "R10");
    rd(8'h40, 32'hFFFF0000, "R10");

    // R5 top field, R6 threshold 14 vs 15
    wr(8'h10, 32'h80000000);
    set_src(63, 1'b1);
    wr(8'h20, 32'hF0000000);
    wr(8'h04, 32'd14);
    rdi(8'h40, 32'h003F0000, 1, 0, "R6");
    wr(8'h04, 32'd15);
    rdi(8'h20, 32'hF0000000, 0, 0, "R5");

    // R11 registered output timing
    wr(8'h04, 32'h0);
    drain();
    @(negedge clk);
    chk("R11", irq_normal, 1'b1);
    src_in[63] = 1'b0;
    #1;
    chk("R11", irq_normal, 1'b1);
    @(negedge clk);
    chk("R11", irq_normal, 1'b0);

    drain();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule